// File: doc/BRIEF.md
# Burst-of-Two Dual-Port Synchronous Memory

This block is a synthesizable behavioural model of a synchronous memory with two independent ports. One port only reads and the other only writes, and each may accept a command in the same cycle. Every access moves exactly two data words. The command carries a word-pair index without the lowest word-address bit. The block supplies that bit itself: 0 for the first beat and 1 for the second.

Write data arrives on the two cycles that follow the write command. Each beat brings its own byte mask, so the two words of one burst can be masked differently. Read data comes back through a fixed two-stage pipeline as two consecutive words flagged by a valid strobe. The ports stay coherent. A read sees every write accepted in the same cycle as the read or earlier, including bytes that are still on their way into the array. The storage array is built from registers. Each half-cycle beat of a double-rate interface is modelled as one cycle of a single clock.

Top module: `bq_sram`

## Requirements
- R1: The read port and the write port each accept a command in the same cycle without interfering with each other.
- R2: Every accepted read produces exactly two consecutive cycles with `rd_valid` high. Every accepted write stores exactly two words.
- R3: The word address is `{index, beat}`. Beat 0 uses low bit 0 and comes first. Beat 1 uses low bit 1 and comes second, on both ports.
- R4: For a write accepted in cycle t, `wr_data` and `wr_be` are sampled in cycle t+1 for beat 0 and in cycle t+2 for beat 1.
- R5: For a read accepted in cycle t, beat 0 is presented after the clock edge that ends cycle t+1. Beat 1 is presented after the edge that ends cycle t+2.
- R6: Byte lane k is bits [9k+8:9k]. A `wr_be[k]` of 1 writes that lane. A `wr_be[k]` of 0 leaves the stored lane unchanged.
- R7: When a read and a write to the same index are accepted in the same cycle, the read returns the new words, merged per byte with the old contents according to each beat's mask.
- R8: A read returns the effect of every write accepted in or before its own command cycle. Writes accepted after the read command do not affect it.
- R9: A command presented in the cycle right after a command was accepted on the same port is ignored.
- R10: Synchronous active-high reset clears `rd_valid`, `rd_data` and every stored word to zero.
- R11: `rd_data` is zero in every cycle in which `rd_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one beat per cycle |
| rst | input | 1 | Synchronous active-high reset |
| wr_cmd | input | 1 | Write command request |
| wr_idx | input | AW | Word-pair index of the write |
| wr_data | input | DW | Write beat data |
| wr_be | input | DW/9 | Per-beat byte-lane write enables |
| rd_cmd | input | 1 | Read command request |
| rd_idx | input | AW | Word-pair index of the read |
| rd_valid | output | 1 | Read beat valid |
| rd_data | output | DW | Read beat data |

## Verification
Write beats are due on the two cycles after the write command. Read words are due after the clock edges that end cycles t+1 and t+2 of a read command accepted in cycle t. The bench drives its inputs one nanosecond after a rising edge and samples `rd_valid` and `rd_data` at that same point after the following edge. A behavioural reference array updated at each rising edge predicts both outputs for the cycle, and the bench compares them on every cycle. Hand-computed values pin the beat order, the byte merges, the same-cycle collision, the ignored commands and the read-before-write ordering to exact cycles.

// File: rtl/bq_pkg.sv
package bq_pkg;

    localparam int LANE_W = 9;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LO   = 2'd1,
        PH_HI   = 2'd2
    } beat_ph_t;

    // A port may take a new command in any cycle except the first beat cycle
    function automatic logic can_accept(input beat_ph_t cur);
        return cur != PH_LO;
    endfunction

    function automatic beat_ph_t ph_next(input logic go, input beat_ph_t cur);
        if (go)
            return PH_LO;
        else if (cur == PH_LO)
            return PH_HI;
        else
            return PH_IDLE;
    endfunction

endpackage

// File: rtl/bq_burst_seq.sv
module bq_burst_seq
    import bq_pkg::*;
#(
    parameter int IW = 4,
    localparam int WAW = IW + 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cmd,
    input  logic [IW-1:0]  idx,
    output logic           go,
    output logic           active,
    output logic [WAW-1:0] word_addr
);

    beat_ph_t       ph_q;
    logic [IW-1:0]  idx_q;

    assign go        = cmd && can_accept(ph_q);
    assign active    = (ph_q != PH_IDLE);
    assign word_addr = {idx_q, (ph_q == PH_HI)};

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= PH_IDLE;
            idx_q <= '0;
        end else begin
            ph_q <= ph_next(go, ph_q);
            if (go)
                idx_q <= idx;
        end
    end

    AST_HI_AFTER_LO: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_HI) |-> ($past(ph_q) == PH_LO)); // R2

endmodule

// File: rtl/bq_word_array.sv
module bq_word_array
    import bq_pkg::*;
#(
    parameter int DW  = 18,
    parameter int WAW = 5,
    localparam int LANES = DW / LANE_W,
    localparam int WORDS = 1 << WAW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [WAW-1:0]   waddr,
    input  logic [DW-1:0]    wdata,
    input  logic [LANES-1:0] wbe,
    input  logic [WAW-1:0]   raddr,
    output logic [DW-1:0]    rdata
);

    logic [DW-1:0] mem [WORDS];
    logic [DW-1:0] old_word;
    logic [DW-1:0] merged;

    assign old_word = mem[waddr];

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign merged[k*LANE_W +: LANE_W] =
            wbe[k] ? wdata[k*LANE_W +: LANE_W] : old_word[k*LANE_W +: LANE_W];
    end

    // Forward the merged word when the read hits the word being written
    assign rdata = (we && (waddr == raddr)) ? merged : mem[raddr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++)
                mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= merged;
        end
    end

    AST_MASKED_KEEP: assert property (@(posedge clk) disable iff (rst)
        (we && (wbe == '0)) |=> (mem[$past(waddr)] == $past(old_word))); // R6

endmodule

// File: rtl/bq_sram.sv
module bq_sram
    import bq_pkg::*;
#(
    parameter int DW = 18,
    parameter int AW = 4,
    localparam int LANES = DW / LANE_W,
    localparam int WAW = AW + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_cmd,
    input  logic [AW-1:0]    wr_idx,
    input  logic [DW-1:0]    wr_data,
    input  logic [LANES-1:0] wr_be,
    input  logic             rd_cmd,
    input  logic [AW-1:0]    rd_idx,
    output logic             rd_valid,
    output logic [DW-1:0]    rd_data
);

    logic           wr_go, wr_act;
    logic [WAW-1:0] wr_waddr;
    logic           rd_go, rd_act;
    logic [WAW-1:0] rd_waddr;
    logic [DW-1:0]  arr_rdata;
    logic           rd_valid_q;
    logic [DW-1:0]  rd_data_q;

    bq_burst_seq #(.IW(AW)) u_wr_seq (
        .clk       (clk),
        .rst       (rst),
        .cmd       (wr_cmd),
        .idx       (wr_idx),
        .go        (wr_go),
        .active    (wr_act),
        .word_addr (wr_waddr)
    );

    bq_burst_seq #(.IW(AW)) u_rd_seq (
        .clk       (clk),
        .rst       (rst),
        .cmd       (rd_cmd),
        .idx       (rd_idx),
        .go        (rd_go),
        .active    (rd_act),
        .word_addr (rd_waddr)
    );

    bq_word_array #(.DW(DW), .WAW(WAW)) u_array (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_act),
        .waddr (wr_waddr),
        .wdata (wr_data),
        .wbe   (wr_be),
        .raddr (rd_waddr),
        .rdata (arr_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid_q <= 1'b0;
            rd_data_q  <= '0;
        end else begin
            rd_valid_q <= rd_act;
            rd_data_q  <= rd_act ? arr_rdata : '0;
        end
    end

    assign rd_valid = rd_valid_q;
    assign rd_data  = rd_data_q;

    AST_RD_LATENCY: assert property (@(posedge clk) disable iff (rst)
        rd_go |-> ##2 rd_valid); // R5

    AST_VALID_PAIRS: assert property (@(posedge clk) disable iff (rst)
        $fell(rd_valid) |-> $past(rd_valid, 2)); // R2

    AST_LOW_BIT_FIRST: assert property (@(posedge clk) disable iff (rst)
        $past(wr_go && !rst) |-> (wr_act && !wr_waddr[0])); // R3

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !rd_valid |-> (rd_data == '0)); // R11

endmodule

// File: tb/test_bq_sram.sv
module test_bq_sram;

    localparam int DW = 18;
    localparam int AW = 4;
    localparam int LANES = DW / 9;
    localparam int NW = 2 * (1 << AW);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             wr_cmd = 1'b0;
    logic [AW-1:0]    wr_idx = '0;
    logic [DW-1:0]    wr_data = '0;
    logic [LANES-1:0] wr_be = '0;
    logic             rd_cmd = 1'b0;
    logic [AW-1:0]    rd_idx = '0;
    logic             rd_valid;
    logic [DW-1:0]    rd_data;

    int errors = 0;
    int checks = 0;
    string cur_tag = "R10";

    always #2 clk = ~clk;

    bq_sram #(.DW(DW), .AW(AW)) i_bq_sram (
        .clk(clk), .rst(rst),
        .wr_cmd(wr_cmd), .wr_idx(wr_idx), .wr_data(wr_data), .wr_be(wr_be),
        .rd_cmd(rd_cmd), .rd_idx(rd_idx),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    // Behavioural reference: word array plus beat counters per port
    logic [DW-1:0] ref_mem [NW];
    int m_wph = 0, m_rph = 0, m_widx = 0, m_ridx = 0;
    logic          exp_v = 1'b0;
    logic [DW-1:0] exp_d = '0;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NW; i++) ref_mem[i] = '0;
            m_wph = 0; m_rph = 0; exp_v = 1'b0; exp_d = '0;
        end else begin
            if (m_wph != 0) begin
                for (int k = 0; k < LANES; k++)
                    if (wr_be[k])
                        ref_mem[m_widx*2 + (m_wph - 1)][k*9 +: 9] = wr_data[k*9 +: 9];
            end
            if (m_rph != 0) begin
                exp_v = 1'b1;
                exp_d = ref_mem[m_ridx*2 + (m_rph - 1)];
            end else begin
                exp_v = 1'b0;
                exp_d = '0;
            end
            if (wr_cmd && m_wph != 1) begin m_widx = int'(wr_idx); m_wph = 1; end
            else if (m_wph == 1) m_wph = 2;
            else m_wph = 0;
            if (rd_cmd && m_rph != 1) begin m_ridx = int'(rd_idx); m_rph = 1; end
            else if (m_rph == 1) m_rph = 2;
            else m_rph = 0;
        end
    end

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        chk({cur_tag, " valid vs model"}, DW'(rd_valid), DW'(exp_v));
        chk({cur_tag, " data vs model"}, rd_data, exp_d);
    endtask

    task automatic do_write(input int idx, input logic [DW-1:0] d0, input logic [LANES-1:0] b0,
                            input logic [DW-1:0] d1, input logic [LANES-1:0] b1);
        wr_cmd = 1'b1; wr_idx = AW'(idx);
        step();
        wr_cmd = 1'b0; wr_data = d0; wr_be = b0;
        step();
        wr_data = d1; wr_be = b1;
        step();
        wr_be = '0;
    endtask

    task automatic do_read(input string tag, input int idx, input logic [DW-1:0] e0, input logic [DW-1:0] e1);
        rd_cmd = 1'b1; rd_idx = AW'(idx);
        step();
        rd_cmd = 1'b0;
        step();
        chk({tag, " beat0 valid"}, DW'(rd_valid), DW'(1));
        chk({tag, " beat0 data"}, rd_data, e0);
        step();
        chk({tag, " beat1 valid"}, DW'(rd_valid), DW'(1));
        chk({tag, " beat1 data"}, rd_data, e1);
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL R5 watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst = 1'b0;
        chk("R10 reset valid", DW'(rd_valid), DW'(0));
        chk("R10 reset data", rd_data, '0);
        do_read("R10 cleared array", 5, '0, '0);
        step();
        chk("R11 idle data", rd_data, '0);

        cur_tag = "R3";
        do_write(3, 18'h12345, 2'b11, 18'h2ABCD, 2'b11);
        do_read("R3 R4 R5 beat order", 3, 18'h12345, 18'h2ABCD);
        step();
        chk("R2 valid ends after two", DW'(rd_valid), DW'(0));

        cur_tag = "R6";
        do_write(3, 18'h3FFFF, 2'b01, 18'h00000, 2'b10);
        do_read("R6 byte masks", 3, 18'h123FF, 18'h001CD);

        // R7 same-cycle collision
        cur_tag = "R7";
        wr_cmd = 1'b1; wr_idx = 4'd7; rd_cmd = 1'b1; rd_idx = 4'd7;
        step();
        wr_cmd = 1'b0; rd_cmd = 1'b0; wr_data = 18'h11111; wr_be = 2'b11;
        step();
        chk("R7 collision beat0", rd_data, 18'h11111);
        wr_data = 18'h22222; wr_be = 2'b01;
        step();
        chk("R7 collision beat1 merged", rd_data, 18'h00022);
        wr_be = '0;
        step();

        // R9 ignored read
        cur_tag = "R9";
        rd_cmd = 1'b1; rd_idx = 4'd3;
        step();
        rd_idx = 4'd7;
        step();
        rd_cmd = 1'b0;
        chk("R9 first read beat0", rd_data, 18'h123FF);
        step();
        chk("R9 first read beat1", rd_data, 18'h001CD);
        step();
        chk("R9 ignored read valid", DW'(rd_valid), DW'(0));

        // R9 ignored write
        wr_cmd = 1'b1; wr_idx = 4'd1;
        step();
        wr_idx = 4'd2; wr_data = 18'h15555; wr_be = 2'b11;
        step();
        wr_cmd = 1'b0; wr_data = 18'h0AAAA;
        step();
        wr_be = '0;
        do_read("R9 ignored write idx", 2, '0, '0);
        do_read("R9 kept write", 1, 18'h15555, 18'h0AAAA);

        // R8 read then write next cycle: old data
        cur_tag = "R8";
        rd_cmd = 1'b1; rd_idx = 4'd1;
        step();
        rd_cmd = 1'b0; wr_cmd = 1'b1; wr_idx = 4'd1;
        step();
        chk("R8 later write beat0 old", rd_data, 18'h15555);
        wr_cmd = 1'b0; wr_data = 18'h3000F; wr_be = 2'b11;
        step();
        chk("R8 later write beat1 old", rd_data, 18'h0AAAA);
        wr_data = 18'h3000F;
        step();
        wr_be = '0;
        // R8 write then read next cycle: new data
        wr_cmd = 1'b1; wr_idx = 4'd6;
        step();
        wr_cmd = 1'b0; wr_data = 18'h01234; wr_be = 2'b11; rd_cmd = 1'b1; rd_idx = 4'd6;
        step();
        rd_cmd = 1'b0; wr_data = 18'h04321;
        step();
        chk("R8 earlier write beat0 new", rd_data, 18'h01234);
        wr_be = '0;
        step();
        chk("R8 earlier write beat1 new", rd_data, 18'h04321);

        // R1 random concurrent traffic against the model
        cur_tag = "R1";
        for (int n = 0; n < 600; n++) begin
            wr_cmd  = 1'($urandom);
            wr_idx  = AW'($urandom);
            wr_data = DW'($urandom);
            wr_be   = LANES'($urandom);
            rd_cmd  = 1'($urandom);
            rd_idx  = AW'($urandom);
            step();
        end
        wr_cmd = 1'b0; rd_cmd = 1'b0; wr_be = '0;
        repeat (4) step();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule